// File: doc/BRIEF.md
# Rotating Interleaved Memory Hub

This block lets sixteen client ports share one memory without ever arbitrating between them. The memory is split into sixteen banks, interleaved on long (32-bit) boundaries. A free-running rotation counter pairs every port with a different bank on every clock. Each port therefore owns exactly one bank per clock, and all sixteen ports can complete a transfer in the same cycle.

A client presents a byte address, write data, an access size and a read/write flag, and holds its valid signal. The request waits until the rotation brings the addressed bank round to that port. The bank is accessed on that clock, and one clock later the port sees a single-cycle done pulse, with read data when the access was a read. A client that walks through consecutive longs, presenting the next address as each done arrives, moves one long per clock. Each bank is a synchronous single-port RAM that is enabled only when its current port has a real access for it.

Top module: `rotary_bank_hub`

## Requirements
- R1: The bank is selected by byte-address bits [5:2], so consecutive longs fall in consecutive banks. The row inside a bank is taken from the bits above bit 5.
- R2: The rotation counter is 0 on the first clock after reset and advances by one every clock, wrapping modulo 16. On that counter value t, port p is paired with bank (t − p) mod 16.
- R3: A held request accesses its bank only on the clock when its port is paired with that bank. The done pulse appears one clock after that access. With the request presented while the counter reads n, the latency is ((bank − n + p) mod 16) + 1 clocks, at most 16.
- R4: When all sixteen ports hold requests for their current banks, all sixteen complete on the same clock.
- R5: A port that presents consecutive long addresses, starting at its current bank and moving on as each done appears, receives sixteen done pulses on sixteen consecutive clocks.
- R6: Size is encoded 0 = byte, 1 = word, 2 = long. A write updates only the bytes from byte offset addr[1:0] up to offset + size − 1, taking the data from the low-order bits of the write data. All other bytes of the long stay unchanged.
- R7: A read returns the addressed bytes right-justified and zero-extended. A write returns read data of zero.
- R8: Three cases are rejected: a word at byte offset 3, a long at any non-zero offset, and size code 3. The rejection comes on the port's slot for the addressed bank, with done and the error flag high together, read data zero, and no change to memory.
- R9: Bank enable b is high only on a clock when the port paired with bank b holds a valid request for bank b that is not rejected.
- R10: During and right after reset, done, error, read data and every bank enable (with no request held) are zero, and the rotation restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 16 | Request held per port |
| req_write | input | 16 | 1 = write, 0 = read, per port |
| req_size | input | 32 | Two bits per port: 0 byte, 1 word, 2 long, 3 invalid |
| req_addr | input | 304 | 19-bit byte address per port |
| req_wdata | input | 512 | 32-bit write data per port, low-justified |
| rsp_done | output | 16 | One-clock completion pulse per port |
| rsp_err | output | 16 | Rejection flag, valid with done |
| rsp_rdata | output | 512 | 32-bit read data per port, valid with done |
| bank_active | output | 16 | Per-bank enable for the current clock |

## Verification
The bench predicts the latency of every request from its own copy of the rotation count. A design whose rotation runs the wrong way, skips a step or is offset by one port returns done on the wrong clock. The sixteen-port burst and the sixteen-long stream fail if two ports could land on one bank, or if a port's slot did not move on every clock. Byte and word writes into a shared long, followed by reads at every offset, expose wrong lane masks or missing right-justification. Rejected requests are followed by a read of the same long, to catch a design that still writes memory or enables the bank for an unaligned access.

// File: rtl/rbh_pkg.sv
package rbh_pkg;

    localparam int LONG_W  = 32;
    localparam int LANES   = LONG_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    // One bank access as seen by a bank after the crossbar
    typedef struct packed {
        logic               en;
        logic               we;
        logic [LANES-1:0]   be;
        logic [LONG_W-1:0]  wdata;
    } lane_req_t;

    function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [1:0] off);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = 4'b0001 << off;
            SZ_WORD: m = 4'b0011 << off;
            SZ_LONG: m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

    function automatic logic is_rejected(size_e sz, logic [1:0] off);
        return (sz == SZ_BAD) ||
               (sz == SZ_WORD && off == 2'd3) ||
               (sz == SZ_LONG && off != 2'd0);
    endfunction

    function automatic logic [LONG_W-1:0] place_lanes(logic [LONG_W-1:0] d, logic [1:0] off);
        return d << (8 * off);
    endfunction

    function automatic logic [LONG_W-1:0] pick_lanes(logic [LONG_W-1:0] q, size_e sz, logic [1:0] off);
        logic [LONG_W-1:0] s;
        logic [LONG_W-1:0] r;
        s = q >> (8 * off);
        case (sz)
            SZ_BYTE: r = {24'd0, s[7:0]};
            SZ_WORD: r = {16'd0, s[15:0]};
            default: r = q;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rbh_rotor.sv
module rbh_rotor #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [SEL_W-1:0] rot
);
    always_ff @(posedge clk) begin
        if (rst) rot <= '0;
        else     rot <= rot + SEL_W'(1);
    end

    AST_ROT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rot == $past(rot) + SEL_W'(1)); // R2
endmodule

// File: rtl/rbh_bank.sv
module rbh_bank
    import rbh_pkg::*;
#(
    parameter int ROW_BITS = 6
) (
    input  logic                clk,
    input  lane_req_t           req,
    input  logic [ROW_BITS-1:0] row,
    output logic [LONG_W-1:0]   q
);
    localparam int DEPTH = 1 << ROW_BITS;

    logic [LONG_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (req.en) begin
            if (req.we) begin
                for (int i = 0; i < LANES; i++) begin
                    if (req.be[i]) mem[row][8*i +: 8] <= req.wdata[8*i +: 8];
                end
            end else begin
                q <= mem[row];
            end
        end
    end
endmodule

// File: rtl/rbh_port.sv
module rbh_port
    import rbh_pkg::*;
#(
    parameter int PORT_ID  = 0,
    parameter int SEL_W    = 4,
    parameter int AW       = 19,
    parameter int ROW_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    rot,
    input  logic                valid,
    input  logic                write,
    input  logic [1:0]          size,
    input  logic [AW-1:0]       addr,
    input  logic [LONG_W-1:0]   wdata,
    output lane_req_t           lane,
    output logic [ROW_BITS-1:0] row,
    output logic [SEL_W-1:0]    sel_q,
    input  logic [LONG_W-1:0]   bank_q,
    output logic                done,
    output logic                err,
    output logic [LONG_W-1:0]   rdata
);
    localparam int BANK_LO = 2;
    localparam int ROW_LO  = BANK_LO + SEL_W;

    size_e             sz;
    logic [1:0]        off;
    logic [SEL_W-1:0]  want_bank;
    logic [SEL_W-1:0]  slot_bank;
    logic              hit;
    logic              bad;
    logic              rd_q;
    size_e             sz_q;
    logic [1:0]        off_q;

    assign sz        = size_e'(size);
    assign off       = addr[1:0];
    assign want_bank = addr[BANK_LO +: SEL_W];
    assign slot_bank = rot - SEL_W'(PORT_ID);
    assign hit       = valid && (want_bank == slot_bank);
    assign bad       = is_rejected(sz, off);
    assign row       = addr[ROW_LO +: ROW_BITS];

    always_comb begin
        lane.en    = hit && !bad;
        lane.we    = write;
        lane.be    = lane_mask(sz, off);
        lane.wdata = place_lanes(wdata, off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            err   <= 1'b0;
            rd_q  <= 1'b0;
            sel_q <= '0;
            sz_q  <= SZ_BYTE;
            off_q <= 2'd0;
        end else begin
            done  <= hit;
            err   <= hit && bad;
            rd_q  <= hit && !bad && !write;
            sel_q <= want_bank;
            sz_q  <= sz;
            off_q <= off;
        end
    end

    assign rdata = rd_q ? pick_lanes(bank_q, sz_q, off_q) : '0;

    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(valid)); // R3
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done && rdata == '0); // R8
endmodule

// File: rtl/rotary_bank_hub.sv
module rotary_bank_hub
    import rbh_pkg::*;
#(
    parameter int NP       = 16,
    parameter int AW       = 19,
    parameter int ROW_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        req_valid,
    input  logic [NP-1:0]        req_write,
    input  logic [2*NP-1:0]      req_size,
    input  logic [NP*AW-1:0]     req_addr,
    input  logic [NP*LONG_W-1:0] req_wdata,
    output logic [NP-1:0]        rsp_done,
    output logic [NP-1:0]        rsp_err,
    output logic [NP*LONG_W-1:0] rsp_rdata,
    output logic [NP-1:0]        bank_active
);
    localparam int SEL_W = $clog2(NP);

    logic [SEL_W-1:0]    rot;
    lane_req_t           port_lane [NP];
    logic [ROW_BITS-1:0] port_row  [NP];
    logic [SEL_W-1:0]    port_sel  [NP];
    logic [LONG_W-1:0]   bank_q    [NP];

    rbh_rotor #(.SEL_W(SEL_W)) u_rotor (
        .clk (clk),
        .rst (rst),
        .rot (rot)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        rbh_port #(
            .PORT_ID (p),
            .SEL_W   (SEL_W),
            .AW      (AW),
            .ROW_BITS(ROW_BITS)
        ) u_port (
            .clk   (clk),
            .rst   (rst),
            .rot   (rot),
            .valid (req_valid[p]),
            .write (req_write[p]),
            .size  (req_size[2*p +: 2]),
            .addr  (req_addr[AW*p +: AW]),
            .wdata (req_wdata[LONG_W*p +: LONG_W]),
            .lane  (port_lane[p]),
            .row   (port_row[p]),
            .sel_q (port_sel[p]),
            .bank_q(bank_q[port_sel[p]]),
            .done  (rsp_done[p]),
            .err   (rsp_err[p]),
            .rdata (rsp_rdata[LONG_W*p +: LONG_W])
        );
    end

    for (genvar b = 0; b < NP; b++) begin : g_bank
        logic [SEL_W-1:0] owner;
        lane_req_t        breq;

        assign owner          = rot - SEL_W'(b);
        assign breq           = port_lane[owner];
        assign bank_active[b] = breq.en;

        rbh_bank #(.ROW_BITS(ROW_BITS)) u_bank (
            .clk (clk),
            .req (breq),
            .row (port_row[owner]),
            .q   (bank_q[b])
        );
    end

    AST_DONE_MATCHES_BANKS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $countones(rsp_done & ~rsp_err) == $countones($past(bank_active))); // R9
endmodule

// File: tb/rotary_bank_hub_tb.sv
module rotary_bank_hub_tb;
    localparam int NP = 16;
    localparam int AW = 19;
    localparam int RB = 6;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NP-1:0]      req_valid = '0;
    logic [NP-1:0]      req_write = '0;
    logic [2*NP-1:0]    req_size  = '0;
    logic [NP*AW-1:0]   req_addr  = '0;
    logic [NP*32-1:0]   req_wdata = '0;
    logic [NP-1:0]      rsp_done;
    logic [NP-1:0]      rsp_err;
    logic [NP*32-1:0]   rsp_rdata;
    logic [NP-1:0]      bank_active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    rotary_bank_hub #(.NP(NP), .AW(AW), .ROW_BITS(RB)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bank_active(bank_active)
    );

    always #10 clk = ~clk;

    // Independent model of the rotation count (R2)
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    typedef struct packed {
        logic [3:0]  port;
        logic        wr;
        logic [1:0]  sz;
        logic [18:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  1'b1, 2'd2, 19'h00040, 32'h11223344, 32'h00000000, 1'b0},
        '{4'd5,  1'b0, 2'd2, 19'h00040, 32'h0,        32'h11223344, 1'b0},
        '{4'd7,  1'b1, 2'd0, 19'h00041, 32'h000000AA, 32'h00000000, 1'b0},
        '{4'd7,  1'b0, 2'd2, 19'h00040, 32'h0,        32'h1122AA44, 1'b0},
        '{4'd1,  1'b1, 2'd1, 19'h00042, 32'h0000BEEF, 32'h00000000, 1'b0},
        '{4'd9,  1'b0, 2'd0, 19'h00043, 32'h0,        32'h000000BE, 1'b0},
        '{4'd9,  1'b0, 2'd1, 19'h00042, 32'h0,        32'h0000BEEF, 1'b0},
        '{4'd0,  1'b0, 2'd1, 19'h00041, 32'h0,        32'h0000EFAA, 1'b0},
        '{4'd4,  1'b1, 2'd2, 19'h00046, 32'hDEADDEAD, 32'h00000000, 1'b1},
        '{4'd4,  1'b1, 2'd1, 19'h00043, 32'h00005555, 32'h00000000, 1'b1},
        '{4'd4,  1'b0, 2'd3, 19'h00040, 32'h0,        32'h00000000, 1'b1},
        '{4'd3,  1'b0, 2'd2, 19'h00040, 32'h0,        32'hBEEFAA44, 1'b0},
        '{4'd15, 1'b1, 2'd2, 19'h0007C, 32'hCAFEF00D, 32'h00000000, 1'b0},
        '{4'd6,  1'b0, 2'd2, 19'h0007C, 32'h0,        32'hCAFEF00D, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input int p, input logic wr, input logic [1:0] sz,
                         input logic [18:0] a, input logic [31:0] wd);
        req_valid[p]          = 1'b1;
        req_write[p]          = wr;
        req_size[2*p +: 2]    = sz;
        req_addr[AW*p +: AW]  = a;
        req_wdata[32*p +: 32] = wd;
    endtask

    // Called at a negative edge; returns at the negative edge where done shows
    task automatic run_req(input int p, input logic wr, input logic [1:0] sz,
                           input logic [18:0] a, input logic [31:0] wd,
                           output logic [31:0] rd, output logic er, output int lat);
        lat = 0;
        rd  = '0;
        er  = 1'b0;
        drive(p, wr, sz, a, wd);
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            if (rsp_done[p]) begin
                rd = rsp_rdata[32*p +: 32];
                er = rsp_err[p];
                break;
            end
        end
        req_valid[p] = 1'b0;
    endtask

    function automatic logic [15:0] onehot(input int b);
        return 16'd1 << b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        int          lat;
        int          n;
        int          bank;
        int          exp_lat;
        logic [31:0] rows [16];

        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        check("R10 done in reset", 32'(rsp_done), 32'd0);
        check("R10 bank enables in reset", 32'(bank_active), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 done after reset", 32'(rsp_done), 32'd0);
        check("R10 err after reset", 32'(rsp_err), 32'd0);

        // Vector table: data, lanes, rejection, latency, bank enables
        for (int v = 0; v < NV; v++) begin
            n       = cyc;
            bank    = int'(VECS[v].addr[5:2]);
            exp_lat = ((bank - n + int'(VECS[v].port)) & 15) + 1;
            drive(int'(VECS[v].port), VECS[v].wr, VECS[v].sz, VECS[v].addr, VECS[v].wd);
            #1;
            // R9: enable only when the slot matches and the access is accepted
            check($sformatf("R9 bank enable vec %0d", v), 32'(bank_active),
                  (exp_lat == 1 && !VECS[v].err) ? 32'(onehot(bank)) : 32'd0);
            run_req(int'(VECS[v].port), VECS[v].wr, VECS[v].sz, VECS[v].addr, VECS[v].wd, rd, er, lat);
            check($sformatf("R3 latency vec %0d", v), 32'(lat), 32'(exp_lat));
            check($sformatf("R6 R7 data vec %0d", v), rd, VECS[v].exp);
            check($sformatf("R8 err flag vec %0d", v), 32'(er), 32'(VECS[v].err));
        end

        // R3: worst-case wait of 15 clocks plus the response clock
        n = cyc;
        run_req(0, 1'b0, 2'd2, 19'((((n + 15) & 15) << 2) | 19'h40), 32'h0, rd, er, lat);
        check("R3 worst-case latency", 32'(lat), 32'd16);

        // R4: every port writes its own current bank at once
        n = cyc;
        for (int p = 0; p < NP; p++)
            drive(p, 1'b1, 2'd2, 19'((2 << 6) | (((n - p) & 15) << 2)), 32'hA0000000 | 32'(p));
        #1;
        check("R4 R9 all banks enabled", 32'(bank_active), 32'h0000FFFF);
        @(negedge clk);
        check("R4 all ports done", 32'(rsp_done), 32'h0000FFFF);
        req_valid = '0;
        for (int b = 0; b < NP; b++) rows[b] = 32'hA0000000 | 32'((n - b) & 15);
        // R4: every port reads its new current bank at once
        n = cyc;
        for (int p = 0; p < NP; p++)
            drive(p, 1'b0, 2'd2, 19'((2 << 6) | (((n - p) & 15) << 2)), 32'h0);
        @(negedge clk);
        req_valid = '0;
        check("R4 all reads done", 32'(rsp_done), 32'h0000FFFF);
        for (int p = 0; p < NP; p++)
            check($sformatf("R1 R4 parallel read port %0d", p),
                  rsp_rdata[32*p +: 32], rows[(n - p) & 15]);

        // R5: stream sixteen consecutive longs from port 3
        begin
            int     s;
            int     got;
            int     edges;
            logic [18:0] base;
            n    = cyc;
            s    = (n - 3) & 15;
            base = 19'((4 << 6) | (s << 2));
            got  = 0;
            edges = 0;
            drive(3, 1'b1, 2'd2, base, 32'h50000000);
            while (got < 16 && edges < 40) begin
                @(negedge clk);
                edges++;
                if (rsp_done[3]) begin
                    got++;
                    if (got < 16) drive(3, 1'b1, 2'd2, base + 19'(4 * got), 32'h50000000 | 32'(got));
                    else req_valid[3] = 1'b0;
                end
            end
            check("R5 stream clocks", 32'(edges), 32'd16);
            for (int i = 0; i < 16; i++) begin
                run_req(8, 1'b0, 2'd2, base + 19'(4 * i), 32'h0, rd, er, lat);
                check($sformatf("R1 R5 stream readback %0d", i), rd, 32'h50000000 | 32'(i));
            end
        end

        // R8: rejected long write leaves memory untouched
        run_req(11, 1'b1, 2'd2, 19'h0007D, 32'h0BADBAD0, rd, er, lat);
        check("R8 misaligned long err", 32'(er), 32'd1);
        run_req(11, 1'b0, 2'd2, 19'h0007C, 32'h0, rd, er, lat);
        check("R8 memory unchanged", rd, 32'hCAFEF00D);

        // R10 R2: mid-run reset restarts rotation at 0
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R10 done cleared by reset", 32'(rsp_done), 32'd0);
        run_req(0, 1'b0, 2'd2, 19'h00040, 32'h0, rd, er, lat);
        check("R2 port 0 meets bank 0 first", 32'(lat), 32'd1);
        run_req(1, 1'b0, 2'd2, 19'h00040, 32'h0, rd, er, lat);
        check("R2 port 1 meets bank 0 next", 32'(lat), 32'd1);
        check("R7 read after reset", rd, 32'hBEEFAA44);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule